// File: doc/BRIEF.md
# Tape Record Word Packer

The packer takes one tape record, delivered as a stream of bytes together with its byte count, and turns it into 16-bit memory word writes for a transfer of bounded length. The host first programs a word-count register, which holds the transfer length as a negative count, and a memory-address register. It then pulses `start` with the record length and streams the bytes in. Each pair of bytes becomes one word, written at the current address, and the address steps after every accepted write.

When the record and the programmed buffer disagree in size, the transfer is clipped to the shorter of the two and status flags report the mismatch. The transfer is not aborted. Bytes beyond the buffer are still taken from the stream and discarded, so the stream stays aligned to record boundaries. At the end of the transfer the word-count register advances by the number of words moved, and `done` pulses for one cycle. A record of zero length is treated as a file mark: no words move and an end-of-file flag is raised.

Top module: `tp_packer`

## Requirements
- R1: A host write of the word-count register while idle stores bits 14:0 as written and copies written bit 14 into bit 15. Written bit 15 is discarded.
- R2: The buffer capacity in words is 16384 minus bits 13:0 of the word-count register. A value of 0 in those bits means 16384.
- R3: If the record byte count exceeds twice the capacity, the overflow flag is set and exactly capacity words are written. The remaining record bytes are accepted and discarded.
- R4: If the record byte count is at most twice the capacity, exactly (count + 1) / 2 words are written.
- R5: An odd record byte count sets the odd flag. When that last byte is packed, the low byte of the final word is 0x00.
- R6: Each word carries the earlier byte of a pair in bits 15:8 and the later byte in bits 7:0.
- R7: Word k of a transfer is written at (start address + k) modulo 2^15. The address register steps by one after each accepted write. Address, data and valid stay stable while `mem_wr_ready` is low.
- R8: Once the transfer finishes, the word-count register equals its programmed value plus the number of words written, modulo 2^16. This value is visible from the cycle after `done`.
- R9: A record byte count of zero writes no words, consumes no bytes and sets the end-of-file flag.
- R10: `done` is high for exactly one cycle. That cycle is the one after the final handshake of the record: the last word write, the last discarded byte, or `start` for an empty record.
- R11: While busy, writes to the word-count and address registers and `start` pulses are ignored.
- R12: The odd, overflow and end-of-file flags are cleared when a transfer starts and hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wc_wr_en | input | 1 | Host write strobe for the word-count register |
| wc_wr_data | input | 16 | Value written to the word-count register |
| ma_wr_en | input | 1 | Host write strobe for the address register |
| ma_wr_data | input | 15 | Value written to the address register |
| wc_value | output | 16 | Current word-count register |
| ma_value | output | 15 | Current address register |
| start | input | 1 | Begin a transfer when idle |
| rec_len | input | 17 | Record byte count, sampled with start |
| byte_valid | input | 1 | Record byte is present |
| byte_data | input | 8 | Record byte |
| byte_ready | output | 1 | Packer accepts a byte this cycle |
| mem_wr_valid | output | 1 | Word write request |
| mem_wr_ready | input | 1 | Memory accepts the word write |
| mem_addr | output | 15 | Word write address |
| mem_data | output | 16 | Word write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| flag_odd | output | 1 | Record had an odd byte count |
| flag_ovf | output | 1 | Record was longer than the buffer |
| flag_eof | output | 1 | Record was a file mark |

## Verification
The bench targets clipping at the buffer edge: a record one byte too long must still drain every byte. A design that stops at the buffer end would leave bytes in the stream and hang or desynchronise the next record. Odd lengths are checked for the zero filler byte and the flag, and a design that dropped the last byte would show one word too few. The address is run across the 2^15 wrap, and the word count is driven to wrap through zero, to catch carries that leak into an extra bit. Register writes and `start` are injected mid-transfer to expose a design that lets the host disturb a transfer in flight, and `done` is timed against the final handshake of each record.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_PUT   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } tp_state_e;
endpackage

// File: rtl/tp_wc_reg.sv
// Word-count register: negative-count load with sign duplication,
// capacity derivation and end-of-transfer accumulation.
module tp_wc_reg #(
  parameter int WC_W     = 16,
  parameter int CAP_BITS = 14,
  localparam int CNT_W   = CAP_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WC_W-1:0]  load_data,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic [WC_W-1:0]  wc_q,
  output logic [CNT_W-1:0] capacity
);
  logic [WC_W-1:0] wc_d;

  always_comb begin
    wc_d = wc_q;
    if (load_en) begin
      wc_d = {load_data[WC_W-2], load_data[WC_W-2:0]};
    end else if (add_en) begin
      wc_d = wc_q + WC_W'(add_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q <= '0;
    end else if (load_en || add_en) begin
      wc_q <= wc_d;
    end
  end

  // 2^CAP_BITS minus the low field; a zero field yields the full size.
  assign capacity = (CNT_W'(1) << CAP_BITS) - {1'b0, wc_q[CAP_BITS-1:0]};
endmodule

// File: rtl/tp_addr_ctr.sv
// Memory-address register with host load and wrapping increment.
module tp_addr_ctr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_data,
  input  logic          inc_en,
  output logic [AW-1:0] ma_q
);
  logic [AW-1:0] ma_d;

  always_comb begin
    ma_d = ma_q;
    if (load_en) begin
      ma_d = load_data;
    end else if (inc_en) begin
      ma_d = ma_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_q <= '0;
    end else if (load_en || inc_en) begin
      ma_q <= ma_d;
    end
  end
endmodule

// File: rtl/tp_byte_pair.sv
// Assembles bytes into big-end-first words; a lone final byte gets a zero filler.
module tp_byte_pair #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take_en,
  input  logic              last_byte,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q
);
  logic              phase_q, phase_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [WORD_W-1:0] word_d;

  assign word_done = take_en && (phase_q || last_byte);

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    word_d  = word_q;
    if (clear) begin
      phase_d = 1'b0;
    end else if (take_en) begin
      if (word_done) begin
        phase_d = 1'b0;
        word_d  = phase_q ? {hi_q, byte_in} : {byte_in, {BYTE_W{1'b0}}};
      end else begin
        phase_d = 1'b1;
        hi_d    = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
      word_q  <= '0;
    end else if (clear || take_en) begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      word_q  <= word_d;
    end
  end
endmodule

// File: rtl/tp_packer.sv
// Tape record word packer: top level control.
module tp_packer
  import tp_pkg::*;
#(
  parameter int AW       = 15,
  parameter int WC_W     = 16,
  parameter int CAP_BITS = 14,
  parameter int LEN_W    = 17,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wc_wr_en,
  input  logic [WC_W-1:0]     wc_wr_data,
  input  logic                ma_wr_en,
  input  logic [AW-1:0]       ma_wr_data,
  output logic [WC_W-1:0]     wc_value,
  output logic [AW-1:0]       ma_value,
  input  logic                start,
  input  logic [LEN_W-1:0]    rec_len,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  output logic                byte_ready,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [2*BYTE_W-1:0] mem_data,
  output logic                busy,
  output logic                done,
  output logic                flag_odd,
  output logic                flag_ovf,
  output logic                flag_eof
);
  localparam int CNT_W = CAP_BITS + 1;
  localparam int CMP_W = (LEN_W > CAP_BITS + 2) ? LEN_W + 1 : CAP_BITS + 3;

  tp_state_e        state_q, state_d;
  logic [LEN_W-1:0] left_b_q, left_b_d;
  logic [CNT_W-1:0] left_w_q, left_w_d;
  logic [CNT_W-1:0] xfer_q, xfer_d;
  logic             odd_q, odd_d, ovf_q, ovf_d, eof_q, eof_d;

  logic [CNT_W-1:0] capacity;
  logic [CMP_W-1:0] len_x, cap2_x, half_x;
  logic             too_long;
  logic [CNT_W-1:0] plan_words;

  logic             idle, wc_load, ma_load, wc_add, ma_inc;
  logic             pair_clear, pair_take, pair_last, word_done;
  logic             reg_en;

  assign idle    = (state_q == ST_IDLE);
  assign wc_load = wc_wr_en && idle;
  assign ma_load = ma_wr_en && idle;

  tp_wc_reg #(.WC_W(WC_W), .CAP_BITS(CAP_BITS)) u_wc (
    .clk(clk), .rst_n(rst_n),
    .load_en(wc_load), .load_data(wc_wr_data),
    .add_en(wc_add), .add_val(xfer_q),
    .wc_q(wc_value), .capacity(capacity)
  );

  tp_addr_ctr #(.AW(AW)) u_ma (
    .clk(clk), .rst_n(rst_n),
    .load_en(ma_load), .load_data(ma_wr_data),
    .inc_en(ma_inc), .ma_q(ma_value)
  );

  tp_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .clear(pair_clear), .take_en(pair_take), .last_byte(pair_last),
    .byte_in(byte_data), .word_done(word_done), .word_q(mem_data)
  );

  // Transfer sizing: clip to the shorter of record and buffer.
  always_comb begin
    len_x      = CMP_W'(rec_len);
    cap2_x     = CMP_W'(capacity) << 1;
    half_x     = (len_x + CMP_W'(1)) >> 1;
    too_long   = (len_x > cap2_x);
    plan_words = too_long ? capacity : CNT_W'(half_x);
  end

  always_comb begin
    state_d    = state_q;
    left_b_d   = left_b_q;
    left_w_d   = left_w_q;
    xfer_d     = xfer_q;
    odd_d      = odd_q;
    ovf_d      = ovf_q;
    eof_d      = eof_q;
    byte_ready   = 1'b0;
    mem_wr_valid = 1'b0;
    pair_clear = 1'b0;
    pair_take  = 1'b0;
    pair_last  = (left_b_q == LEN_W'(1));
    ma_inc     = 1'b0;
    wc_add     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pair_clear = 1'b1;
          left_b_d   = rec_len;
          left_w_d   = plan_words;
          xfer_d     = plan_words;
          odd_d      = rec_len[0];
          ovf_d      = too_long;
          eof_d      = (rec_len == '0);
          state_d    = (rec_len == '0) ? ST_FIN : ST_FILL;
        end
      end
      ST_FILL: begin
        byte_ready = 1'b1;
        if (byte_valid) begin
          pair_take = 1'b1;
          left_b_d  = left_b_q - LEN_W'(1);
          if (word_done) state_d = ST_PUT;
        end
      end
      ST_PUT: begin
        mem_wr_valid = 1'b1;
        if (mem_wr_ready) begin
          ma_inc   = 1'b1;
          left_w_d = left_w_q - CNT_W'(1);
          if (left_w_q == CNT_W'(1)) begin
            state_d = (left_b_q != '0) ? ST_DRAIN : ST_FIN;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_DRAIN: begin
        byte_ready = 1'b1;
        if (byte_valid) begin
          left_b_d = left_b_q - LEN_W'(1);
          if (left_b_q == LEN_W'(1)) state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        wc_add  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign reg_en = (state_d != state_q) || byte_ready || mem_wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      left_b_q <= '0;
      left_w_q <= '0;
      xfer_q   <= '0;
      odd_q    <= 1'b0;
      ovf_q    <= 1'b0;
      eof_q    <= 1'b0;
    end else if (reg_en) begin
      state_q  <= state_d;
      left_b_q <= left_b_d;
      left_w_q <= left_w_d;
      xfer_q   <= xfer_d;
      odd_q    <= odd_d;
      ovf_q    <= ovf_d;
      eof_q    <= eof_d;
    end
  end

  assign mem_addr = ma_value;
  assign busy     = !idle;
  assign done     = (state_q == ST_FIN);
  assign flag_odd = odd_q;
  assign flag_ovf = ovf_q;
  assign flag_eof = eof_q;
endmodule

// File: rtl/tp_packer_chk.sv
module tp_packer_chk #(
  parameter int AW   = 15,
  parameter int WC_W = 16,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            byte_ready,
  input logic            mem_wr_valid,
  input logic            mem_wr_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_data,
  input logic [AW-1:0]   ma_value,
  input logic [WC_W-1:0] wc_value,
  input logic            wc_wr_en,
  input logic [WC_W-1:0] wc_wr_data,
  input logic            flag_eof
);
  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: address steps by one after each accepted write
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready) |=> (ma_value == AW'($past(ma_value) + 1'b1)));

  // R7: a stalled write holds its request
  a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_addr) && $stable(mem_data)));

  // R1: idle load duplicates bit 14 into bit 15
  a_r1_wc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wc_wr_en && !busy) |=>
      (wc_value == {$past(wc_wr_data[WC_W-2]), $past(wc_wr_data[WC_W-2:0])}));

  // R11: word count frozen during a transfer until the finishing cycle
  a_r11_wc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(wc_value));

  // R9: a file mark produces no write
  a_r9_eof_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    flag_eof |-> !mem_wr_valid);

  // R3: byte intake and word output never overlap
  a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_ready && mem_wr_valid));
endmodule

bind tp_packer tp_packer_chk #(.AW(AW), .WC_W(WC_W), .DW(2*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .byte_ready(byte_ready), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .ma_value(ma_value), .wc_value(wc_value), .wc_wr_en(wc_wr_en),
  .wc_wr_data(wc_wr_data), .flag_eof(flag_eof)
);

// File: tb/tp_packer_test.sv
module tp_packer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wc_wr_en;
  logic [15:0] wc_wr_data;
  logic        ma_wr_en;
  logic [14:0] ma_wr_data;
  logic [15:0] wc_value;
  logic [14:0] ma_value;
  logic        start;
  logic [16:0] rec_len;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready;
  logic        mem_wr_valid;
  logic        mem_wr_ready;
  logic [14:0] mem_addr;
  logic [15:0] mem_data;
  logic        busy, done, flag_odd, flag_ovf, flag_eof;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_evt = 0;
  int wr_cnt = 0;
  logic [30:0] exp_q[$];

  tp_packer uut (
    .clk(clk), .rst_n(rst_n),
    .wc_wr_en(wc_wr_en), .wc_wr_data(wc_wr_data),
    .ma_wr_en(ma_wr_en), .ma_wr_data(ma_wr_data),
    .wc_value(wc_value), .ma_value(ma_value),
    .start(start), .rec_len(rec_len),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done),
    .flag_odd(flag_odd), .flag_ovf(flag_ovf), .flag_eof(flag_eof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 mem_wr_ready = ((cyc % 4) != 2);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rec_byte(input int k, input int i);
    return 8'((k * 37 + i * 11 + 5) & 255);
  endfunction

  // Per-clock reference comparison of handshakes
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_valid && mem_wr_ready) begin
        last_evt = cyc;
        wr_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R4 extra word write", {mem_addr, mem_data}, 0);
        end else begin
          logic [30:0] e;
          e = exp_q.pop_front();
          check(mem_addr == e[30:16], "R7 word address", mem_addr, e[30:16]);
          check(mem_data == e[15:0], "R5/R6 word data", mem_data, e[15:0]);
        end
      end
      if (byte_valid && byte_ready) last_evt = cyc;
      if (start && !busy) last_evt = cyc;
      if (done) check(cyc == last_evt + 1, "R10 done timing", cyc, last_evt + 1);
    end
  end

  task automatic run_record(input int k, input int len, input logic [15:0] wc_prog,
                            input logic [14:0] ma_prog, input bit poke);
    logic [15:0] wc_exp;
    int cap, n;
    bit ovf;
    @(posedge clk); #1;
    wc_wr_en = 1'b1; wc_wr_data = wc_prog;
    ma_wr_en = 1'b1; ma_wr_data = ma_prog;
    @(posedge clk); #1;
    wc_wr_en = 1'b0; ma_wr_en = 1'b0;
    wc_exp = {wc_prog[14], wc_prog[14:0]};
    @(negedge clk);
    check(wc_value == wc_exp, "R1 word-count load", wc_value, wc_exp);
    cap = 16384 - int'(wc_exp[13:0]);
    ovf = (len > 2 * cap);
    n = ovf ? cap : (len + 1) / 2;
    for (int j = 0; j < n; j++) begin
      logic [7:0] lo;
      lo = (2 * j + 1 < len) ? rec_byte(k, 2 * j + 1) : 8'h00;
      exp_q.push_back({15'(int'(ma_prog) + j), rec_byte(k, 2 * j), lo});
    end
    wr_cnt = 0;
    @(posedge clk); #1;
    start = 1'b1; rec_len = 17'(len);
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      if ((i % 3) == 2) begin
        byte_valid = 1'b0;
        @(posedge clk); #1;
      end
      byte_valid = 1'b1; byte_data = rec_byte(k, i);
      forever begin
        @(negedge clk);
        if (byte_ready) break;
      end
      @(posedge clk); #1;
      // R11: host writes and a second start while busy
      wc_wr_en = poke && (i == 0); wc_wr_data = 16'h1234;
      ma_wr_en = poke && (i == 0); ma_wr_data = 15'h2222;
      start = poke && (i == 0); rec_len = 17'd3;
    end
    byte_valid = 1'b0;
    wc_wr_en = 1'b0; ma_wr_en = 1'b0; start = 1'b0;
    forever begin
      @(negedge clk);
      if (done) break;
    end
    check(wr_cnt == n, "R3/R4 word count written", wr_cnt, n);
    check(exp_q.size() == 0, "R3/R4 all words seen", exp_q.size(), 0);
    check(flag_ovf == ovf, "R3/R12 overflow flag", flag_ovf, ovf);
    check(flag_odd == len[0], "R5/R12 odd flag", flag_odd, len[0]);
    check(flag_eof == (len == 0), "R9/R12 eof flag", flag_eof, len == 0);
    exp_q.delete();
    @(negedge clk);
    check(!done, "R10 done single cycle", done, 0);
    check(!busy, "R10 idle after done", busy, 0);
    check(wc_value == 16'(int'(wc_exp) + n), "R8 final word count", wc_value,
          16'(int'(wc_exp) + n));
    check(ma_value == 15'(int'(ma_prog) + n), "R7/R11 final address", ma_value,
          15'(int'(ma_prog) + n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wc_wr_en = 1'b0; wc_wr_data = '0;
    ma_wr_en = 1'b0; ma_wr_data = '0;
    start = 1'b0; rec_len = '0;
    byte_valid = 1'b0; byte_data = '0;
    mem_wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(wc_value == 0 && ma_value == 0, "reset registers", {wc_value, ma_value}, 0);
    check(!busy && !done && !byte_ready && !mem_wr_valid, "reset control",
          {busy, done, byte_ready, mem_wr_valid}, 0);
    check(!flag_odd && !flag_ovf && !flag_eof, "reset flags",
          {flag_odd, flag_ovf, flag_eof}, 0);

    // R1: written bit 15 discarded, bit 14 duplicated
    run_record(0, 0, 16'hBFF0, 15'h0010, 1'b0);   // R9 file mark, bit15 dropped
    run_record(1, 6, 16'h7FFC, 15'h0100, 1'b0);   // R4 R6 plain even record
    run_record(2, 5, 16'h7FFC, 15'h0200, 1'b0);   // R5 odd record, filler byte
    run_record(3, 9, 16'h7FFD, 15'h0300, 1'b0);   // R3 overflow, drain, R8 wrap to 0
    run_record(4, 8, 16'h7FFC, 15'h0400, 1'b0);   // R2 exact fit, no overflow
    run_record(5, 6, 16'h7FF0, 15'h7FFE, 1'b0);   // R7 address wrap
    run_record(6, 10, 16'h7FF8, 15'h0500, 1'b1);  // R11 pokes while busy
    run_record(7, 7, 16'h7FFE, 15'h0600, 1'b1);   // R3 odd overflow with pokes
    run_record(8, 0, 16'h7FFE, 15'h0700, 1'b0);   // R9 R12 eof after overflow

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule